// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the host-side register interface of a small Ethernet controller. The host reaches it through a 4-bit offset, an 8-bit data bus and separate read and write strobes. Offset 0 is the command register, and it can be reached from every page. Its two top bits pick one of three register pages, and every other offset is decoded inside the page they pick. Several offsets decode to one register on a write and to a different one on a read.

The block holds the following state:
- the ring-buffer page pointers;
- the transmit page and length;
- the remote-DMA start address and byte count;
- three configuration bytes;
- the station address and multicast filter bytes;
- the interrupt status and mask registers.

It drives a level interrupt and a run flag. It sends one-cycle start and transmit pulses to the engines that move packets. Those engines report completion events through a status input. The block carries no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `nic_regfile`

## Requirements
- R1: After reset:
  - the command register reads 0x21;
  - interrupt status reads 0x80 (only bit 7, reset complete);
  - the mask is 0x00 and `irq` is low;
  - `tx_go` and `start_pulse` are low;
  - all other registers are 0x00.
- R2: Offset 0 always accesses the command register.
  - For offsets 1 to 15, the page is command bits 7:6.
  - The register chosen is page*16 + offset.
  - Page 3 holds no registers: writes to it have no effect.
- R3: The three 16-bit registers are each written one byte at a time on page 0:
  - transmit length: offset 5 is the low byte, offset 6 the high byte;
  - remote start address: offsets 8 (low) and 9 (high);
  - remote byte count: offsets 10 (low) and 11 (high).
  A write changes only the byte it addresses.
- R4: Interrupt status is at page 0 offset 7. Writing 1 to a bit clears that bit. Writing 0 leaves the bit unchanged.
- R5: `irq` is high exactly when (status AND mask) is non-zero. It follows the same clock edge that changes either register.
  - The mask is written at page 0 offset 15.
  - The mask is read back at page 2 offset 15.
- R6: A command write sets status bit 6 (remote DMA complete) at that edge when all of these hold:
  - bit 1 (start) is set;
  - bit 3 (remote read) or bit 4 (remote write) is set;
  - the remote byte count is zero.
- R7: A command write with bit 1 (start) and bit 2 (transmit) both set does three things:
  - it raises `tx_go` for exactly the next cycle;
  - `tx_base` is then the transmit page times 256 (page written at page 0 offset 4), and `tx_len` is the transmit length;
  - it sets status bit 1 (transmit OK).
  Any command write with bit 1 set raises `start_pulse` for the next cycle.
- R8: On page 1:
  - offsets 1 to 6 hold the six station address bytes;
  - offset 7 holds the current receive page;
  - offsets 8 to 15 hold the eight multicast filter bytes.
  All of them can be read and written.
- R9: Each bit set in `evt_in` sets the matching status bit. The bits are:
  - 0: receive OK;
  - 1: transmit OK;
  - 2: receive error;
  - 3: transmit error;
  - 4: ring overwrite;
  - 5: counter overflow;
  - 6: remote DMA complete;
  - 7: reset complete.
  If a set and a clear hit the same bit in one cycle, the set wins.
- R10: Reads on page 0 return:
  - offset 3: boundary page;
  - offset 7: interrupt status;
  - offsets 8 and 9: remote address low and high.
  Reads on page 2 return what was written on page 0:
  - offsets 1 and 2: ring start and stop pages;
  - offset 4: transmit page;
  - offsets 12, 13 and 14: the three configuration bytes;
  - offset 15: the mask.
  The ring start page is write-only on page 0 and reads as 0x00 there.
- R11: The following read as 0x00:
  - every offset not listed above, all of page 3 included;
  - every offset while `rd_en` is low.
  `running` equals command bit 1 AND NOT command bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| rd_en | input | 1 | Read strobe; rdata valid combinationally while high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| evt_in | input | 8 | Status set events from packet engines |
| irq | output | 1 | Level interrupt |
| running | output | 1 | Controller started and not stopped |
| start_pulse | output | 1 | One-cycle pulse after a start command |
| tx_go | output | 1 | One-cycle transmit request |
| tx_base | output | 16 | Transmit buffer byte address |
| tx_len | output | 16 | Transmit byte count |

## Verification
The assertions are checked on every cycle. They cover:
- the status value in the first cycle after reset;
- write-one-to-clear on the status register;
- the zero-count remote DMA shortcut;
- the transmit pulse together with its status bit;
- the silence of writes to page 3;
- a masked interrupt staying low.

Some behaviours only the directed scenarios can show:
- which register each page and offset pair reaches on a read versus a write;
- byte-lane independence of the wide registers;
- set-over-clear priority on the status register;
- readback of the station and multicast bytes.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PW = 2;

  // command bit positions
  localparam int C_STOP  = 0;
  localparam int C_START = 1;
  localparam int C_TX    = 2;
  localparam int C_RRD   = 3;
  localparam int C_RWR   = 4;

  // status bit positions
  localparam int S_TXOK = 1;
  localparam int S_RDC  = 6;

  localparam logic [DW-1:0] CMD_RST = 8'h21;
  localparam logic [DW-1:0] ISR_RST = 8'h80;

  typedef enum logic [PW-1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;
endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode
  import nic_regs_pkg::*;
#(
  parameter int AW = 4,
  parameter int PW = 2
) (
  input  logic [PW-1:0]    page,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PW+AW-1:0] idx,
  output logic             wr_cmd,
  output logic             wr_reg,
  output logic             rd_reg
);
  logic at_cmd;
  logic page_ok;

  always_comb begin
    at_cmd  = (addr == '0);
    page_ok = (page != PW'(PG3));
    idx     = {page, addr};
    wr_cmd  = wr_en && at_cmd;
    wr_reg  = wr_en && !at_cmd && page_ok;
    rd_reg  = rd_en && !at_cmd && page_ok;
  end
endmodule

// File: rtl/nic_wide_reg.sv
module nic_wide_reg #(
  parameter int BYTES = 2,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BYTES-1:0]    lane_we,
  input  logic [DW-1:0]       wdata,
  output logic [BYTES*DW-1:0] q
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[g*DW +: DW] <= '0;
      else if (lane_we[g]) q[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/nic_addr_table.sv
module nic_addr_table #(
  parameter int N  = 14,
  parameter int DW = 8,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ent [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ent[g] <= '0;
      else if (we && (sel == TW'(g)))    ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (sel == TW'(i)) rdata = ent[i];
  end
endmodule

// File: rtl/nic_isr_ctrl.sv
module nic_isr_ctrl #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_VAL = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] isr,
  output logic [DW-1:0] imr,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= RST_VAL;
      imr <= '0;
    end else begin
      isr <= (isr & ~clr_vec) | set_vec;
      if (mask_we) imr <= mask_wdata;
    end
  end

  assign irq = |(isr & imr);
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int STN_BYTES = 6,
  parameter int MC_BYTES  = 8,
  localparam int PW  = 2,
  localparam int NT  = STN_BYTES + MC_BYTES,
  localparam int TW  = $clog2(NT),
  localparam int MC0 = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] evt_in,
  output logic          irq,
  output logic          running,
  output logic          start_pulse,
  output logic          tx_go,
  output logic [2*DW-1:0] tx_base,
  output logic [2*DW-1:0] tx_len
);
  logic [DW-1:0] cmd_q, pstart_q, pstop_q, bnry_q, tpsr_q, curpg_q;
  logic [DW-1:0] rxcfg_q, txcfg_q, dcfg_q;
  logic [2*DW-1:0] rsar_q, rcnt_q, tcnt_q;
  logic [DW-1:0] isr_q, imr_q;
  logic [PW+AW-1:0] idx;
  logic wr_cmd, wr_reg, rd_reg;
  logic start_q, txgo_q;
  logic [DW-1:0] set_vec, clr_vec;
  logic tbl_hit, tbl_we;
  logic [TW-1:0] tbl_sel;
  logic [DW-1:0] tbl_rdata;
  logic [1:0] tcnt_we, rsar_we, rcnt_we;
  logic on_pg1;

  nic_page_decode #(.AW(AW), .PW(PW)) u_dec (
    .page(cmd_q[DW-1 -: PW]), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .idx(idx), .wr_cmd(wr_cmd), .wr_reg(wr_reg), .rd_reg(rd_reg)
  );

  // byte-lane strobes of the wide registers
  always_comb begin
    tcnt_we = {wr_reg && idx == 6'h06, wr_reg && idx == 6'h05};
    rsar_we = {wr_reg && idx == 6'h09, wr_reg && idx == 6'h08};
    rcnt_we = {wr_reg && idx == 6'h0B, wr_reg && idx == 6'h0A};
  end

  nic_wide_reg #(.BYTES(2), .DW(DW)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .lane_we(tcnt_we), .wdata(wdata), .q(tcnt_q));
  nic_wide_reg #(.BYTES(2), .DW(DW)) u_rsar (
    .clk(clk), .rst_n(rst_n), .lane_we(rsar_we), .wdata(wdata), .q(rsar_q));
  nic_wide_reg #(.BYTES(2), .DW(DW)) u_rcnt (
    .clk(clk), .rst_n(rst_n), .lane_we(rcnt_we), .wdata(wdata), .q(rcnt_q));

  // page 1 table: station bytes then multicast bytes
  always_comb begin
    on_pg1  = (idx[PW+AW-1 -: PW] == PW'(PG1));
    tbl_hit = 1'b0;
    tbl_sel = '0;
    if (int'(addr) >= 1 && int'(addr) <= STN_BYTES) begin
      tbl_hit = 1'b1;
      tbl_sel = TW'(int'(addr) - 1);
    end else if (int'(addr) >= MC0 && int'(addr) < MC0 + MC_BYTES) begin
      tbl_hit = 1'b1;
      tbl_sel = TW'(int'(addr) - MC0 + STN_BYTES);
    end
    tbl_we = wr_reg && on_pg1 && tbl_hit;
  end

  nic_addr_table #(.N(NT), .DW(DW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel),
    .wdata(wdata), .rdata(tbl_rdata));

  // status sources
  always_comb begin
    set_vec = evt_in;
    if (wr_cmd && wdata[C_START] && (wdata[C_RRD] || wdata[C_RWR]) && rcnt_q == '0)
      set_vec[S_RDC] = 1'b1;
    if (wr_cmd && wdata[C_START] && wdata[C_TX])
      set_vec[S_TXOK] = 1'b1;
    clr_vec = (wr_reg && idx == 6'h07) ? wdata : '0;
  end

  nic_isr_ctrl #(.DW(DW), .RST_VAL(ISR_RST)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(wr_reg && idx == 6'h0F), .mask_wdata(wdata),
    .isr(isr_q), .imr(imr_q), .irq(irq));

  // byte registers and command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST;
      pstart_q <= '0;
      pstop_q  <= '0;
      bnry_q   <= '0;
      tpsr_q   <= '0;
      curpg_q  <= '0;
      rxcfg_q  <= '0;
      txcfg_q  <= '0;
      dcfg_q   <= '0;
      start_q  <= 1'b0;
      txgo_q   <= 1'b0;
    end else begin
      start_q <= wr_cmd && wdata[C_START];
      txgo_q  <= wr_cmd && wdata[C_START] && wdata[C_TX];
      if (wr_cmd) cmd_q <= wdata;
      if (wr_reg) begin
        case (idx)
          6'h01:   pstart_q <= wdata;
          6'h02:   pstop_q  <= wdata;
          6'h03:   bnry_q   <= wdata;
          6'h04:   tpsr_q   <= wdata;
          6'h0C:   rxcfg_q  <= wdata;
          6'h0D:   txcfg_q  <= wdata;
          6'h0E:   dcfg_q   <= wdata;
          6'h17:   curpg_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  // read mux: read and write decode differ per offset
  always_comb begin
    rdata = '0;
    if (rd_en && addr == '0) begin
      rdata = cmd_q;
    end else if (rd_reg) begin
      case (idx)
        6'h03:   rdata = bnry_q;
        6'h07:   rdata = isr_q;
        6'h08:   rdata = rsar_q[DW-1:0];
        6'h09:   rdata = rsar_q[2*DW-1:DW];
        6'h17:   rdata = curpg_q;
        6'h21:   rdata = pstart_q;
        6'h22:   rdata = pstop_q;
        6'h24:   rdata = tpsr_q;
        6'h2C:   rdata = rxcfg_q;
        6'h2D:   rdata = txcfg_q;
        6'h2E:   rdata = dcfg_q;
        6'h2F:   rdata = imr_q;
        default: rdata = (on_pg1 && tbl_hit) ? tbl_rdata : '0;
      endcase
    end
  end

  assign running     = cmd_q[C_START] & ~cmd_q[C_STOP];
  assign start_pulse = start_q;
  assign tx_go       = txgo_q;
  assign tx_base     = {tpsr_q, {DW{1'b0}}};
  assign tx_len      = tcnt_q;
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic [7:0]  evt_in,
  input logic        irq,
  input logic        start_pulse,
  input logic        tx_go,
  input logic [15:0] tx_base,
  input logic [15:0] tx_len,
  input logic [7:0]  isr_q,
  input logic [7:0]  imr_q,
  input logic [7:0]  cmd_q,
  input logic [15:0] rcnt_q
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (isr_q == 8'h80 && imr_q == 8'h00));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h7 && cmd_q[7:6] == 2'd0 && evt_in == 8'h00)
      |=> ((isr_q & $past(wdata)) == 8'h00));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == 8'h00) |-> !irq);

  a_r6_zero_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0 && wdata[1] && (wdata[3] || wdata[4]) && rcnt_q == 16'h0)
      |=> isr_q[6]);

  a_r7_tx_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0 && wdata[1] && wdata[2]) |=> (tx_go && isr_q[1]));

  a_r7_tx_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> start_pulse);

  a_r2_page3_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 4'h0 && cmd_q[7:6] == 2'd3)
      |=> ($stable(tx_len) && $stable(tx_base) && $stable(imr_q)));
endmodule

bind nic_regfile nic_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .evt_in(evt_in), .irq(irq), .start_pulse(start_pulse), .tx_go(tx_go),
  .tx_base(tx_base), .tx_len(tx_len), .isr_q(isr_q), .imr_q(imr_q),
  .cmd_q(cmd_q), .rcnt_q(rcnt_q)
);

// File: tb/tb_nic_regfile.sv
`timescale 1ns/1ps
module tb_nic_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, evt_in = '0;
  logic [7:0] rdata;
  logic irq, running, start_pulse, tx_go;
  logic [15:0] tx_base, tx_len;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  nic_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq),
    .running(running), .start_pulse(start_pulse), .tx_go(tx_go),
    .tx_base(tx_base), .tx_len(tx_len));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic evt(input logic [7:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'h0, d); chk("R1 cmd", {8'h0, d}, 16'h0021);
    rd(4'h7, d); chk("R1 status", {8'h0, d}, 16'h0080);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tx_go", {15'h0, tx_go}, 16'h0);
    chk("R11 running", {15'h0, running}, 16'h0);
    rd(4'h1, d); chk("R11 idle read", {8'h0, d}, 16'h0);
    chk("R11 no rd_en", {8'h0, rdata}, 16'h0);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    wr(4'h5, 8'h34); wr(4'h6, 8'h12);
    chk("R3 tx_len", tx_len, 16'h1234);
    wr(4'h5, 8'hAB);
    chk("R3 low lane only", tx_len, 16'h12AB);
    wr(4'h8, 8'h78); wr(4'h9, 8'h56);
    wr(4'h9, 8'h9A);
    rd(4'h8, d); chk("R3 rsar lo kept", {8'h0, d}, 16'h0078);
    rd(4'h9, d); chk("R3 rsar hi", {8'h0, d}, 16'h009A);
  endtask

  task automatic t_split();
    logic [7:0] d;
    wr(4'h3, 8'h4C);
    rd(4'h3, d); chk("R10 boundary", {8'h0, d}, 16'h004C);
    wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'hD, 8'h02);
    rd(4'h1, d); chk("R10 start page write-only on page 0", {8'h0, d}, 16'h0);
    wr(4'h0, 8'hA1);
    rd(4'h0, d); chk("R2 cmd on page 2", {8'h0, d}, 16'h00A1);
    rd(4'h1, d); chk("R10 page2 start", {8'h0, d}, 16'h0046);
    rd(4'h2, d); chk("R10 page2 stop", {8'h0, d}, 16'h0080);
    rd(4'hD, d); chk("R10 page2 txcfg", {8'h0, d}, 16'h0002);
    rd(4'h3, d); chk("R11 page2 unlisted", {8'h0, d}, 16'h0);
    wr(4'h0, 8'h21);
  endtask

  task automatic t_page3();
    logic [7:0] d;
    wr(4'h0, 8'hE1);
    wr(4'hF, 8'hFF);
    wr(4'h5, 8'h00);
    rd(4'h5, d); chk("R11 page3 read", {8'h0, d}, 16'h0);
    wr(4'h0, 8'h21);
    chk("R2 page3 write ignored", tx_len, 16'h12AB);
    evt(8'h01);
    chk("R2 page3 mask untouched", {15'h0, irq}, 16'h0);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_status();
    logic [7:0] d;
    evt(8'h05);
    rd(4'h7, d); chk("R9 event set", {8'h0, d}, 16'h0005);
    wr(4'h7, 8'h01);
    rd(4'h7, d); chk("R4 clear one", {8'h0, d}, 16'h0004);
    wr(4'h7, 8'h00);
    rd(4'h7, d); chk("R4 zero keeps", {8'h0, d}, 16'h0004);
    @(negedge clk); addr = 4'h7; wdata = 8'h04; wr_en = 1'b1; evt_in = 8'h04;
    @(negedge clk); wr_en = 1'b0; evt_in = '0;
    rd(4'h7, d); chk("R9 set wins", {8'h0, d}, 16'h0004);
    wr(4'h7, 8'hFF);
    rd(4'h7, d); chk("R4 all clear", {8'h0, d}, 16'h0);
  endtask

  task automatic t_irq();
    wr(4'hF, 8'h02);
    evt(8'h01);
    chk("R5 masked bit", {15'h0, irq}, 16'h0);
    evt(8'h02);
    chk("R5 unmasked bit", {15'h0, irq}, 16'h1);
    wr(4'h7, 8'h02);
    chk("R5 cleared", {15'h0, irq}, 16'h0);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_dma();
    logic [7:0] d;
    wr(4'h0, 8'h0A);
    rd(4'h7, d); chk("R6 zero count done", {8'h0, d}, 16'h0040);
    chk("R11 running", {15'h0, running}, 16'h1);
    wr(4'h7, 8'hFF);
    wr(4'hA, 8'h03);
    wr(4'h0, 8'h12);
    rd(4'h7, d); chk("R6 nonzero count", {8'h0, d}, 16'h0);
    wr(4'h0, 8'h21);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    wr(4'h4, 8'h40);
    wr(4'h0, 8'h26);
    chk("R7 tx_go", {15'h0, tx_go}, 16'h1);
    chk("R7 start_pulse", {15'h0, start_pulse}, 16'h1);
    chk("R7 tx_base", tx_base, 16'h4000);
    chk("R7 tx_len", tx_len, 16'h12AB);
    @(negedge clk);
    chk("R7 single cycle", {15'h0, tx_go}, 16'h0);
    rd(4'h7, d); chk("R7 tx status", {8'h0, d}, 16'h0002);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_station();
    logic [7:0] d;
    wr(4'h0, 8'h61);
    for (int i = 1; i < 16; i++) wr(4'(i), 8'(8'h80 + i));
    for (int i = 1; i < 16; i++) begin
      rd(4'(i), d);
      chk("R8 page1 readback", {8'h0, d}, {8'h0, 8'(8'h80 + i)});
    end
    wr(4'h0, 8'hA1);
    rd(4'hF, d); chk("R5 mask readback", {8'h0, d}, 16'h0002);
    wr(4'h0, 8'h21);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bytes();
    t_split();
    t_page3();
    t_status();
    t_irq();
    t_dma();
    t_tx();
    t_station();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule